// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block gathers a parameterized set of level-sensitive peripheral interrupt lines and drives one interrupt request line into each CPU's hardware interrupt input. The inputs are organized as 32-bit words. Every CPU owns a private bank of mask words, so any input can be steered to any mix of CPUs by unmasking it in the right banks. There is no priority encoding and no pending queue. Software scans every status word to find active sources.

Software never rewrites a whole mask word. It writes ones to a set word to mask sources, or to a clear word to unmask them, so two agents can never lose each other's update. Inputs are sampled through a two-flop synchronizer, and no latching is applied, so a status bit follows the live input level. A word-addressed register bus reaches every CPU's bank. Read data is registered and appears on the cycle after the read strobe. It then holds until the next read.

Top module: `irqAggregator`

## Requirements
- R1: `NUM_IRQ` is one of 64, 96, 128 or 160, giving `NUM_IRQ/32` status words. A read of register select 0 for word w returns bit i equal to input 32w+i as seen through two synchronizing flops.
- R2: The bus address is split as follows: bits [1:0] pick the register (0 status, 1 mask status, 2 mask set, 3 mask clear), bits [4:2] pick the word, and the bits above pick the CPU. `busRdData` is loaded on the clock edge that samples `busRdEn` and holds between reads.
- R3: After reset every mask bit of every CPU is 1, reads of mask status return all ones, and every `irqOut` bit is 0.
- R4: A write to a CPU's mask set word sets exactly the mask bits where the write data is 1 and leaves the others unchanged.
- R5: A write to a CPU's mask clear word clears exactly the mask bits where the write data is 1 and leaves the others unchanged.
- R6: `irqOut[c]` is 1 exactly when some synchronized input is 1 and its bit in CPU c's mask is 0. It is registered one cycle after the synchronizer output and mask.
- R7: Mask writes addressed to one CPU never change another CPU's mask or output.
- R8: Reads of the mask set and mask clear words return zero.
- R9: A word index of `NUM_IRQ/32` or above, or a CPU index of `NUM_CPU` or above, is unused. Writes there change no mask, and reads there return zero.
- R10: Status and outputs are not latched. When an input returns to 0, its status bit and any output it was driving return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irqIn | input | NUM_IRQ | Level interrupt inputs from peripherals |
| busAddr | input | ADDR_W | Register word address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Registered read data |
| irqOut | output | NUM_CPU | One interrupt request per CPU |

## Verification
The assertions assume that at most one bus access targets the mask bank in a cycle, and that `irqIn` may change at any time because it is synchronized before use. The checks that relate outputs to mask state take for granted that reset has been applied once before any bus strobe.

The stimulus drives a single read or write per cycle on the falling edge. It changes the interrupt levels only while the bus is idle. It waits enough cycles for the synchronizer and the output register to settle before it compares status or output values.

// File: rtl/irqAggPkg.sv
package irqAggPkg;
  localparam int WORD_BITS    = 32;
  localparam int WORD_FIELD_W = 3;
  localparam int CPU_FIELD_W  = 4;

  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_MASKRD  = 2'd1,
    SEL_MASKSET = 2'd2,
    SEL_MASKCLR = 2'd3
  } regSelT;

  typedef struct packed {
    logic                    rdEn;
    logic                    wrSet;
    logic                    wrClr;
    logic                    hit;
    regSelT                  regSel;
    logic [WORD_FIELD_W-1:0] word;
    logic [CPU_FIELD_W-1:0]  cpu;
  } ctrlStrobeT;
endpackage

// File: rtl/irqAggCtrl.sv
module irqAggCtrl
  import irqAggPkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int NUM_CPU   = 3,
  parameter int CPU_W     = 2,
  parameter int ADDR_W    = 7
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output ctrlStrobeT        strb
);
  logic [WORD_FIELD_W-1:0] wordIdx;
  logic [CPU_W-1:0]        cpuIdx;
  logic                    inRange;

  assign wordIdx = busAddr[WORD_FIELD_W+1:2];
  assign cpuIdx  = busAddr[ADDR_W-1:WORD_FIELD_W+2];
  assign inRange = (int'(wordIdx) < NUM_WORDS) && (int'(cpuIdx) < NUM_CPU);

  always_comb begin
    strb        = '0;
    strb.regSel = regSelT'(busAddr[1:0]);
    strb.word   = wordIdx;
    strb.cpu    = CPU_FIELD_W'(cpuIdx);
    strb.hit    = inRange;
    strb.rdEn   = busRdEn;
    strb.wrSet  = busWrEn && inRange && (busAddr[1:0] == SEL_MASKSET);
    strb.wrClr  = busWrEn && inRange && (busAddr[1:0] == SEL_MASKCLR);
  end
endmodule

// File: rtl/irqAggDatapath.sv
module irqAggDatapath
  import irqAggPkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int NUM_CPU   = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_WORDS*WORD_BITS-1:0]   irqIn,
  input  ctrlStrobeT                       strb,
  input  logic [WORD_BITS-1:0]             busWrData,
  output logic [WORD_BITS-1:0]             busRdData,
  output logic [NUM_CPU-1:0]               irqOut
);
  localparam int NUM_IRQ = NUM_WORDS * WORD_BITS;

  logic [NUM_IRQ-1:0] syncA, syncB;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0] maskQ;
  logic [NUM_CPU-1:0] anyPend;
  logic [WORD_BITS-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= irqIn;
      syncB <= syncA;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : gCpu
    for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
      logic sel;
      assign sel = (strb.cpu == CPU_FIELD_W'(c)) && (strb.word == WORD_FIELD_W'(w));
      always_ff @(posedge clk) begin
        if (rst)
          maskQ[c][w*WORD_BITS +: WORD_BITS] <= '1;
        else if (strb.wrSet && sel)
          maskQ[c][w*WORD_BITS +: WORD_BITS] <= maskQ[c][w*WORD_BITS +: WORD_BITS] | busWrData;
        else if (strb.wrClr && sel)
          maskQ[c][w*WORD_BITS +: WORD_BITS] <= maskQ[c][w*WORD_BITS +: WORD_BITS] & ~busWrData;
      end
    end

    assign anyPend[c] = |(syncB & ~maskQ[c]);

    always_ff @(posedge clk) begin
      if (rst) irqOut[c] <= 1'b0;
      else     irqOut[c] <= anyPend[c];
    end

    assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (rst)
      (&maskQ[c]) |=> !irqOut[c]);
  end

  always_comb begin
    rdNext = '0;
    if (strb.hit) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        for (int w = 0; w < NUM_WORDS; w++) begin
          if (strb.cpu == CPU_FIELD_W'(c) && strb.word == WORD_FIELD_W'(w)) begin
            if (strb.regSel == SEL_STATUS)
              rdNext = syncB[w*WORD_BITS +: WORD_BITS];
            else if (strb.regSel == SEL_MASKRD)
              rdNext = maskQ[c][w*WORD_BITS +: WORD_BITS];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            busRdData <= '0;
    else if (strb.rdEn) busRdData <= rdNext;
  end

  assert_wo_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (strb.rdEn && strb.regSel[1]) |=> (busRdData == '0));

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(strb.wrSet || strb.wrClr) |=> (maskQ == $past(maskQ)));

  assert_set_only_R4: assert property (@(posedge clk) disable iff (rst)
    strb.wrSet |=> ((maskQ & $past(maskQ)) == $past(maskQ)));

  assert_clear_only_R5: assert property (@(posedge clk) disable iff (rst)
    strb.wrClr |=> ((maskQ | $past(maskQ)) == $past(maskQ)));
endmodule

// File: rtl/irqAggregator.sv
module irqAggregator
  import irqAggPkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 3,
  localparam int NUM_WORDS = NUM_IRQ / WORD_BITS,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int ADDR_W = 2 + WORD_FIELD_W + CPU_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_IRQ-1:0]   irqIn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [WORD_BITS-1:0] busWrData,
  input  logic                 busRdEn,
  output logic [WORD_BITS-1:0] busRdData,
  output logic [NUM_CPU-1:0]   irqOut
);
  ctrlStrobeT strb;

  initial begin
    assert_irq_count_R1: assert ((NUM_IRQ % WORD_BITS) == 0 && NUM_WORDS >= 2 && NUM_WORDS <= 5)
      else $error("NUM_IRQ must be 64, 96, 128 or 160");
    assert_cpu_count_R7: assert (NUM_CPU >= 1 && NUM_CPU <= (1 << CPU_FIELD_W))
      else $error("NUM_CPU out of range");
  end

  irqAggCtrl #(
    .NUM_WORDS(NUM_WORDS), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W)
  ) uCtrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .strb(strb)
  );

  irqAggDatapath #(
    .NUM_WORDS(NUM_WORDS), .NUM_CPU(NUM_CPU)
  ) uDp (
    .clk(clk), .rst(rst), .irqIn(irqIn), .strb(strb), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_irqAggregator.sv
module tb_irqAggregator;
  localparam int NIRQ = 96;
  localparam int NCPU = 3;
  localparam int NW   = NIRQ / 32;
  localparam int AW   = 7;

  logic clk = 0, rst = 1;
  logic [NIRQ-1:0] irqIn = '0;
  logic [AW-1:0] busAddr = '0;
  logic busWrEn = 0, busRdEn = 0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NCPU-1:0] irqOut;

  int checks = 0, errors = 0;
  logic [31:0] maskModel [NCPU][8];
  logic [31:0] expQ[$];
  string tagQ[$];
  logic rdSeen = 0;

  always #5 clk = ~clk;

  irqAggregator #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU)) dut (
    .clk(clk), .rst(rst), .irqIn(irqIn), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData), .irqOut(irqOut)
  );

  function automatic logic [AW-1:0] mkAddr(int cpu, int word, int sel);
    return {cpu[1:0], word[2:0], sel[1:0]};
  endfunction

  function automatic logic [31:0] modelRead(int cpu, int word, int sel);
    if (cpu >= NCPU || word >= NW) return '0;
    if (sel == 0) return irqIn[word*32 +: 32];
    if (sel == 1) return maskModel[cpu][word];
    return '0;
  endfunction

  task automatic settle(int n = 4);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(int cpu, int word, int sel, logic [31:0] data);
    @(negedge clk);
    busAddr = mkAddr(cpu, word, sel); busWrData = data; busWrEn = 1;
    if (cpu < NCPU && word < NW) begin
      if (sel == 2) maskModel[cpu][word] |= data;
      if (sel == 3) maskModel[cpu][word] &= ~data;
    end
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic busRead(int cpu, int word, int sel, string tag);
    @(negedge clk);
    busAddr = mkAddr(cpu, word, sel); busRdEn = 1;
    expQ.push_back(modelRead(cpu, word, sel));
    tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 0;
  endtask

  always @(posedge clk) rdSeen <= busRdEn;

  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (busRdData !== e) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", t, busRdData, e);
      end
    end
  end

  task automatic checkIrq(string tag);
    logic [NCPU-1:0] exp;
    for (int c = 0; c < NCPU; c++) begin
      logic any = 0;
      for (int w = 0; w < NW; w++)
        any |= |(irqIn[w*32 +: 32] & ~maskModel[c][w]);
      exp[c] = any;
    end
    checks++;
    if (irqOut !== exp) begin
      errors++;
      $display("FAIL %s: irqOut got %b expected %b", tag, irqOut, exp);
    end
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCPU; c++)
      for (int w = 0; w < 8; w++) maskModel[c][w] = '1;
    repeat (3) @(negedge clk);
    rst = 0;
    settle(1);
    checkIrq("R3 reset outputs low");
    for (int c = 0; c < NCPU; c++) busRead(c, 1, 1, "R3 reset mask all ones");

    // R1: status words reflect inputs, outputs stay masked
    irqIn = {32'h8000_0001, 32'h00F0_0F00, 32'hA5A5_5A5A};
    settle();
    for (int w = 0; w < NW; w++) busRead(0, w, 0, "R1 status word");
    busRead(2, 2, 0, "R1 status seen from another CPU bank");
    checkIrq("R3 all masked");

    // R5 / R6 / R7: unmask some bits on CPU0 only
    busWrite(0, 1, 3, 32'h0000_0F00);
    busRead(0, 1, 1, "R5 clear changes only addressed bits");
    settle(2);
    checkIrq("R6 unmasked source raises CPU0, R7 others quiet");
    busRead(1, 1, 1, "R7 other CPU mask untouched");

    // R4: mask again on CPU0
    busWrite(0, 1, 2, 32'h0000_0300);
    busRead(0, 1, 1, "R4 set changes only addressed bits");
    settle(2);
    checkIrq("R6 partial remask keeps output");
    busWrite(0, 1, 2, 32'h0000_0C00);
    settle(2);
    checkIrq("R4 full remask drops output");

    // R8: write-only registers read zero
    busRead(0, 0, 2, "R8 set word reads zero");
    busRead(1, 2, 3, "R8 clear word reads zero");

    // R9: unused words and CPUs
    busWrite(2, 3, 3, 32'hFFFF_FFFF);
    busWrite(3, 0, 3, 32'hFFFF_FFFF);
    busWrite(2, 7, 3, 32'hFFFF_FFFF);
    settle(2);
    checkIrq("R9 unused writes leave outputs");
    busRead(2, 2, 1, "R9 valid mask unchanged");
    busRead(2, 0, 1, "R9 valid mask unchanged word0");
    busRead(3, 0, 1, "R9 unused CPU reads zero");
    busRead(1, 4, 0, "R9 unused word reads zero");

    // R6 boundary: top input to CPU2
    busWrite(2, 2, 3, 32'h8000_0000);
    settle(2);
    checkIrq("R6 highest input reaches CPU2");
    busRead(2, 2, 1, "R5 top bit cleared");

    // R2: read data holds between reads
    settle(3);
    checks++;
    if (busRdData !== 32'h7FFF_FFFF) begin
      errors++;
      $display("FAIL R2 read data hold: got %h expected %h", busRdData, 32'h7FFF_FFFF);
    end

    // R10: input falls, status and output follow
    irqIn[95] = 1'b0;
    settle();
    checkIrq("R10 output falls with input");
    busRead(0, 2, 0, "R10 status follows input");

    // R7: same bit unmasked on two CPUs
    irqIn[40] = 1'b1;
    busWrite(1, 1, 3, 32'h0000_0100);
    busWrite(2, 1, 3, 32'h0000_0100);
    settle();
    checkIrq("R7 shared source reaches two CPUs");
    irqIn[40] = 1'b0;
    settle();
    checkIrq("R10 shared source released");

    settle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule